// File: doc/BRIEF.md
# Message Buffer Interrupt Flag Controller

This block holds the completion flags and interrupt enables for a bank of 64 message buffers in a CAN controller. The buffers are split into a low group (buffers 0 to 31) and a high group (buffers 32 to 63), and each group is seen by software as one 32-bit mask word and one 32-bit flag word. The protocol engine reports each finished transmission or reception with a strobe and the buffer index, and the matching flag goes high. Software reads the flag words to find which buffers finished, then acknowledges them by writing ones.

A single interrupt request leaves the block. It is high whenever at least one buffer has both its flag and its enable set. Changing an enable bit takes effect on the request immediately, with no new event needed. The block also gives the buffer memory a per-buffer write-block vector. When abort mode is on, a CPU write to a transmit buffer whose completion flag has not yet been acknowledged must be refused.

Top module: `mbuf_irq_ctrl`

## Requirements
- R1: After reset, every mask bit and every flag bit is 0, `irqOut` is 0 and `wrBlock` is all zeros.
- R2: A clock edge with `doneValid` high and `doneIdx` = n sets the flag of buffer n. Flags of buffers 32..63 read at offset 0x8 and those of buffers 0..31 at offset 0xC. In each register word, bit k holds buffer (32 × group + k), so the most significant bit is the highest buffer of the group.
- R3: A write to a flag word (0x8 high group, 0xC low group) clears each flag whose data bit is 1 and leaves each flag whose data bit is 0 unchanged.
- R4: A write to offset 0x0 replaces the mask bits of buffers 32..63, and a write to offset 0x4 replaces those of buffers 0..31. The bit layout is the same as in R2. Reads return the current contents with no wait state.
- R5: After every clock edge, `irqOut` is 1 exactly when some buffer has both mask and flag equal to 1 after that edge. A change of mask or flag changes `irqOut` at the same edge.
- R6: If a completion event and a software clear target the same flag at the same edge, the flag ends up set.
- R7: `wrBlock[n]` is 1 only when `abortEn` is 1, `bufIsTx[n]` is 1 and the flag of buffer n is 1. With `abortEn` low, every bit is 0.
- R8: `wrBlock` is registered. After an edge it reflects the `abortEn`, `bufIsTx` and flag values present just before that edge, so it follows a flag change one cycle later.
- R9: Writes to an address whose two low bits are not 00 change nothing, and reads at such an address return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| regAddr | input | 4 | Byte address of the register access |
| regWrEn | input | 1 | Register write strobe |
| regWrData | input | 32 | Register write data |
| regRdData | output | 32 | Register read data, combinational from `regAddr` |
| doneValid | input | 1 | Completion event strobe from the protocol engine |
| doneIdx | input | 6 | Buffer index of the completion event |
| bufIsTx | input | 64 | Per-buffer direction, 1 = transmit |
| abortEn | input | 1 | Abort mode enable |
| irqOut | output | 1 | Combined interrupt request |
| wrBlock | output | 64 | Per-buffer CPU write refusal |

## Verification
Several properties are checked on every cycle. The interrupt line must agree with the masked flags. A strobed completion must leave its flag set, including when a clear arrives at the same edge. A flag may only fall where a clear was written. Write-block bits may appear only for buffers flagged in the previous cycle, and never when abort mode was off. The address decoder must produce at most one strobe, and none for a misaligned address.

Some behaviour can only be shown by the bench's scenarios. These are the bit-to-buffer mapping across all 64 buffers, the exact contents read back after mixed clear patterns, the one-cycle lag of the write-block vector against a varied set of direction patterns, and the fact that misaligned writes leave all four words untouched.

// File: rtl/mbuf_irq_pkg.sv
package mbuf_irq_pkg;
  timeunit 1ns;
  timeprecision 100ps;

  localparam int BANK_W   = 32;
  localparam int BANK_CNT = 2;
  localparam int ADDR_W   = 4;

  // read selection decoded from the register address
  typedef enum logic [2:0] {
    SEL_MASK_HI,
    SEL_MASK_LO,
    SEL_FLAG_HI,
    SEL_FLAG_LO,
    SEL_NONE
  } regSel_e;

  // strobes from control to datapath
  typedef struct packed {
    logic maskWrHi;
    logic maskWrLo;
    logic flagClrHi;
    logic flagClrLo;
  } ctlStrobe_t;
endpackage

// File: rtl/mbuf_irq_ctl.sv
module mbuf_irq_ctl
  import mbuf_irq_pkg::*;
#(
  parameter int BUF_PER_BANK = BANK_W,
  parameter int AW           = ADDR_W
) (
  input  logic                                       clk,
  input  logic                                       rstN,
  input  logic [AW-1:0]                              regAddr,
  input  logic                                       regWrEn,
  input  logic                                       doneValid,
  input  logic [$clog2(BUF_PER_BANK*BANK_CNT)-1:0]   doneIdx,
  output ctlStrobe_t                                 strobe,
  output regSel_e                                    rdSel,
  output logic [BUF_PER_BANK*BANK_CNT-1:0]           setVec
);
  timeunit 1ns;
  timeprecision 100ps;

  localparam int NUM_BUF = BUF_PER_BANK * BANK_CNT;
  localparam int IDX_W   = $clog2(NUM_BUF);

  logic aligned;

  // only word-aligned addresses inside the 16-byte window decode
  assign aligned = (regAddr[1:0] == 2'b00) && ((regAddr >> 4) == '0);

  always_comb begin
    rdSel = SEL_NONE;
    if (aligned) begin
      unique case (regAddr[3:2])
        2'd0: rdSel = SEL_MASK_HI;
        2'd1: rdSel = SEL_MASK_LO;
        2'd2: rdSel = SEL_FLAG_HI;
        default: rdSel = SEL_FLAG_LO;
      endcase
    end
  end

  always_comb begin
    strobe           = '0;
    strobe.maskWrHi  = regWrEn && (rdSel == SEL_MASK_HI);
    strobe.maskWrLo  = regWrEn && (rdSel == SEL_MASK_LO);
    strobe.flagClrHi = regWrEn && (rdSel == SEL_FLAG_HI);
    strobe.flagClrLo = regWrEn && (rdSel == SEL_FLAG_LO);
  end

  // one-hot decode of the completion index
  for (genvar i = 0; i < NUM_BUF; i++) begin : g_setDec
    assign setVec[i] = doneValid && (doneIdx == IDX_W'(i));
  end

  // R2: a completion strobe selects exactly one buffer
  p_one_set_r2: assert property (@(posedge clk) disable iff (!rstN)
    doneValid |-> ($countones(setVec) == 1));

  // R2: no completion strobe, no set
  p_idle_no_set_r2: assert property (@(posedge clk) disable iff (!rstN)
    !doneValid |-> (setVec == '0));

  // R9: at most one register strobe, none for a misaligned address
  p_strobe_excl_r9: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(strobe));

  p_misalign_quiet_r9: assert property (@(posedge clk) disable iff (!rstN)
    (regAddr[1:0] != 2'b00) |-> (strobe == '0 && rdSel == SEL_NONE));
endmodule

// File: rtl/mbuf_irq_dp.sv
module mbuf_irq_dp
  import mbuf_irq_pkg::*;
#(
  parameter int BUF_PER_BANK = BANK_W
) (
  input  logic                                clk,
  input  logic                                rstN,
  input  ctlStrobe_t                          strobe,
  input  regSel_e                             rdSel,
  input  logic [BUF_PER_BANK*BANK_CNT-1:0]    setVec,
  input  logic [BUF_PER_BANK-1:0]             wrData,
  input  logic [BUF_PER_BANK*BANK_CNT-1:0]    bufIsTx,
  input  logic                                abortEn,
  output logic [BUF_PER_BANK-1:0]             rdData,
  output logic                                irqOut,
  output logic [BUF_PER_BANK*BANK_CNT-1:0]    wrBlock
);
  timeunit 1ns;
  timeprecision 100ps;

  localparam int NUM_BUF = BUF_PER_BANK * BANK_CNT;

  logic [NUM_BUF-1:0] maskQ, maskNext;
  logic [NUM_BUF-1:0] flagQ, flagNext;
  logic [NUM_BUF-1:0] clrVec;
  logic [NUM_BUF-1:0] blkQ;
  logic               irqQ;

  // group 0 holds the low buffers, group 1 the high buffers
  for (genvar b = 0; b < BANK_CNT; b++) begin : g_bank
    logic maskWr;
    logic flagClr;
    if (b == 0) begin : g_lo
      assign maskWr  = strobe.maskWrLo;
      assign flagClr = strobe.flagClrLo;
    end else begin : g_hi
      assign maskWr  = strobe.maskWrHi;
      assign flagClr = strobe.flagClrHi;
    end
    assign maskNext[b*BUF_PER_BANK +: BUF_PER_BANK] =
      maskWr ? wrData : maskQ[b*BUF_PER_BANK +: BUF_PER_BANK];
    assign clrVec[b*BUF_PER_BANK +: BUF_PER_BANK] =
      flagClr ? wrData : '0;
  end

  // a set on the same edge as a clear wins
  assign flagNext = (flagQ & ~clrVec) | setVec;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      maskQ <= '0;
      flagQ <= '0;
      irqQ  <= 1'b0;
      blkQ  <= '0;
    end else begin
      maskQ <= maskNext;
      flagQ <= flagNext;
      irqQ  <= |(maskNext & flagNext);
      blkQ  <= {NUM_BUF{abortEn}} & bufIsTx & flagQ;
    end
  end

  always_comb begin
    unique case (rdSel)
      SEL_MASK_HI: rdData = maskQ[NUM_BUF-1 -: BUF_PER_BANK];
      SEL_MASK_LO: rdData = maskQ[BUF_PER_BANK-1:0];
      SEL_FLAG_HI: rdData = flagQ[NUM_BUF-1 -: BUF_PER_BANK];
      SEL_FLAG_LO: rdData = flagQ[BUF_PER_BANK-1:0];
      default:     rdData = '0;
    endcase
  end

  assign irqOut  = irqQ;
  assign wrBlock = blkQ;

  // R5: the request tracks the masked flags on every cycle
  p_irq_match_r5: assert property (@(posedge clk) disable iff (!rstN)
    irqOut == |(maskQ & flagQ));

  // R6: a strobed completion is never lost, even against a clear
  p_set_sticks_r6: assert property (@(posedge clk) disable iff (!rstN)
    (setVec != '0) |=> ((flagQ & $past(setVec)) == $past(setVec)));

  // R3: a flag only falls where a one was written to clear it
  p_clear_only_r3: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (($past(flagQ) & ~flagQ & ~$past(clrVec)) == '0));

  // R7: no refusal while abort mode was off
  p_abort_off_r7: assert property (@(posedge clk) disable iff (!rstN)
    !abortEn |=> (wrBlock == '0));

  // R8: refusal only for buffers flagged one cycle earlier
  p_blk_lag_r8: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ((wrBlock & ~$past(flagQ)) == '0));
endmodule

// File: rtl/mbuf_irq_ctrl.sv
module mbuf_irq_ctrl
  import mbuf_irq_pkg::*;
(
  input  logic          clk,
  input  logic          rstN,
  input  logic [3:0]    regAddr,
  input  logic          regWrEn,
  input  logic [31:0]   regWrData,
  output logic [31:0]   regRdData,
  input  logic          doneValid,
  input  logic [5:0]    doneIdx,
  input  logic [63:0]   bufIsTx,
  input  logic          abortEn,
  output logic          irqOut,
  output logic [63:0]   wrBlock
);
  timeunit 1ns;
  timeprecision 100ps;

  ctlStrobe_t  strobe;
  regSel_e     rdSel;
  logic [63:0] setVec;

  mbuf_irq_ctl #(
    .BUF_PER_BANK (BANK_W),
    .AW           (ADDR_W)
  ) u_ctl (
    .clk       (clk),
    .rstN      (rstN),
    .regAddr   (regAddr),
    .regWrEn   (regWrEn),
    .doneValid (doneValid),
    .doneIdx   (doneIdx),
    .strobe    (strobe),
    .rdSel     (rdSel),
    .setVec    (setVec)
  );

  mbuf_irq_dp #(
    .BUF_PER_BANK (BANK_W)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .rdSel   (rdSel),
    .setVec  (setVec),
    .wrData  (regWrData),
    .bufIsTx (bufIsTx),
    .abortEn (abortEn),
    .rdData  (regRdData),
    .irqOut  (irqOut),
    .wrBlock (wrBlock)
  );
endmodule

// File: tb/mbuf_irq_ctrl_tb.sv
module mbuf_irq_ctrl_tb;
  timeunit 1ns;
  timeprecision 100ps;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [3:0]  regAddr = '0;
  logic        regWrEn = 1'b0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic        doneValid = 1'b0;
  logic [5:0]  doneIdx = '0;
  logic [63:0] bufIsTx = '0;
  logic        abortEn = 1'b0;
  logic        irqOut;
  logic [63:0] wrBlock;

  // bench model
  logic [63:0] mMask = '0;
  logic [63:0] mFlag = '0;
  logic [63:0] mBlk  = '0;
  logic        mIrq  = 1'b0;

  int  nChecks = 0;
  int  nErrors = 0;
  bit  finished = 1'b0;

  always #5 clk = ~clk;

  mbuf_irq_ctrl u_dut (
    .clk       (clk),
    .rstN      (rstN),
    .regAddr   (regAddr),
    .regWrEn   (regWrEn),
    .regWrData (regWrData),
    .regRdData (regRdData),
    .doneValid (doneValid),
    .doneIdx   (doneIdx),
    .bufIsTx   (bufIsTx),
    .abortEn   (abortEn),
    .irqOut    (irqOut),
    .wrBlock   (wrBlock)
  );

  task automatic chk(input string rq, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (act !== exp) begin
      nErrors++;
      $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp);
    end
  endtask

  // one clock cycle of stimulus; model follows the requirements
  task automatic step(input logic we, input logic [3:0] a, input logic [31:0] d,
                      input logic dv, input logic [5:0] di);
    logic [63:0] nMask;
    logic [63:0] nFlag;
    @(negedge clk);
    regWrEn = we; regAddr = a; regWrData = d; doneValid = dv; doneIdx = di;
    nMask = mMask;
    nFlag = mFlag;
    if (we && a[1:0] == 2'b00) begin           // R9: misaligned ignored
      case (a[3:2])
        2'd0: nMask[63:32] = d;                // R4
        2'd1: nMask[31:0]  = d;
        2'd2: nFlag[63:32] = nFlag[63:32] & ~d; // R3
        default: nFlag[31:0] = nFlag[31:0] & ~d;
      endcase
    end
    if (dv) nFlag[di] = 1'b1;                  // R2, R6: set wins
    mBlk  = {64{abortEn}} & bufIsTx & mFlag;   // R7, R8: pre-edge values
    mMask = nMask;
    mFlag = nFlag;
    mIrq  = |(nMask & nFlag);                  // R5
    @(posedge clk);
    #1;
    regWrEn = 1'b0;
    doneValid = 1'b0;
  endtask

  task automatic checkAll(input string rq);
    regAddr = 4'h0; #0.5; chk(rq, "maskHi", {32'h0, regRdData}, {32'h0, mMask[63:32]});
    regAddr = 4'h4; #0.5; chk(rq, "maskLo", {32'h0, regRdData}, {32'h0, mMask[31:0]});
    regAddr = 4'h8; #0.5; chk(rq, "flagHi", {32'h0, regRdData}, {32'h0, mFlag[63:32]});
    regAddr = 4'hC; #0.5; chk(rq, "flagLo", {32'h0, regRdData}, {32'h0, mFlag[31:0]});
    chk(rq, "irqOut", {63'h0, irqOut}, {63'h0, mIrq});
    chk(rq, "wrBlock", wrBlock, mBlk);
  endtask

  initial begin
    #2_000_000;
    if (!finished) begin
      nChecks++;
      nErrors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", nChecks, nErrors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    @(posedge clk);
    #1;
    checkAll("R1");

    // R2: set every buffer in turn, masks still zero
    for (int n = 0; n < 64; n++) begin
      step(1'b0, 4'h0, 32'h0, 1'b1, 6'(n));
      checkAll("R2");
    end

    // R3: zeros do nothing, ones clear
    step(1'b1, 4'h8, 32'h0, 1'b0, 6'd0);         checkAll("R3");
    step(1'b1, 4'hC, 32'h0, 1'b0, 6'd0);         checkAll("R3");
    step(1'b1, 4'hC, 32'hA5A5_A5A5, 1'b0, 6'd0); checkAll("R3");
    step(1'b1, 4'h8, 32'hFFFF_0000, 1'b0, 6'd0); checkAll("R3");
    step(1'b1, 4'h8, 32'h0000_0F0F, 1'b0, 6'd0); checkAll("R3");

    // R4, R5: walk a single mask bit over all buffers
    for (int n = 0; n < 64; n++) begin
      step(1'b1, (n >= 32) ? 4'h0 : 4'h4, 32'h1 << (n % 32), 1'b0, 6'd0);
      checkAll("R5");
      step(1'b1, (n >= 32) ? 4'h0 : 4'h4, 32'h0, 1'b0, 6'd0);
      checkAll("R4");
    end

    // R5: mask on, then clear the flag, then mask off
    step(1'b1, 4'h4, 32'hFFFF_FFFF, 1'b0, 6'd0); checkAll("R5");
    step(1'b1, 4'hC, 32'hFFFF_FFFF, 1'b0, 6'd0); checkAll("R5");
    step(1'b0, 4'h0, 32'h0, 1'b1, 6'd7);         checkAll("R5");
    step(1'b1, 4'h4, 32'h0, 1'b0, 6'd0);         checkAll("R5");
    step(1'b1, 4'h0, 32'h8000_0000, 1'b1, 6'd63); checkAll("R5");

    // R6: set and clear together on the same flag
    step(1'b1, 4'hC, 32'h0000_0060, 1'b1, 6'd5); checkAll("R6");
    step(1'b1, 4'h8, 32'h8000_0001, 1'b1, 6'd32); checkAll("R6");
    step(1'b1, 4'h8, 32'h8000_0000, 1'b1, 6'd63); checkAll("R6");

    // R7, R8: write-block against direction patterns
    for (int p = 0; p < 6; p++) begin
      for (int n = 0; n < 64; n += 3) step(1'b0, 4'h0, 32'h0, 1'b1, 6'(n));
      case (p)
        0: bufIsTx = 64'hF0F0_F0F0_F0F0_F0F0;
        1: bufIsTx = 64'h0F0F_0F0F_0F0F_0F0F;
        2: bufIsTx = '1;
        3: bufIsTx = 64'h8000_0001_8000_0001;
        4: bufIsTx = 64'h1234_5678_9ABC_DEF0;
        default: bufIsTx = '0;
      endcase
      abortEn = 1'b0;
      step(1'b0, 4'h0, 32'h0, 1'b0, 6'd0); checkAll("R7");
      step(1'b0, 4'h0, 32'h0, 1'b0, 6'd0); checkAll("R7");
      abortEn = 1'b1;
      step(1'b0, 4'h0, 32'h0, 1'b0, 6'd0); checkAll("R7");
      // clear low flags: wrBlock follows one cycle later
      step(1'b1, 4'hC, 32'hFFFF_FFFF, 1'b0, 6'd0); checkAll("R8");
      step(1'b0, 4'h0, 32'h0, 1'b1, 6'd1);         checkAll("R8");
      step(1'b1, 4'h8, 32'hFFFF_FFFF, 1'b0, 6'd0); checkAll("R8");
      step(1'b0, 4'h0, 32'h0, 1'b0, 6'd0);         checkAll("R8");
    end

    // R9: misaligned writes ignored, misaligned reads give zero
    step(1'b0, 4'h0, 32'h0, 1'b1, 6'd40);
    step(1'b1, 4'h1, 32'hFFFF_FFFF, 1'b0, 6'd0); checkAll("R9");
    step(1'b1, 4'h6, 32'hFFFF_FFFF, 1'b0, 6'd0); checkAll("R9");
    step(1'b1, 4'hB, 32'hFFFF_FFFF, 1'b0, 6'd0); checkAll("R9");
    step(1'b1, 4'hF, 32'hFFFF_FFFF, 1'b0, 6'd0); checkAll("R9");
    for (int a = 1; a < 16; a += 2) begin
      regAddr = 4'(a);
      #0.5;
      chk("R9", "misaligned read", {32'h0, regRdData}, 64'h0);
    end

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", nChecks, nErrors);
    $finish;
  end
endmodule